// File: doc/BRIEF.md
# Hypervisor Control Field Address Validator

This block checks the execution and exit control fields of a virtual machine before entry is allowed. It takes the relevant control bits, the physical addresses of the I/O bitmaps, the priority-shadow page, the interrupt-controller access page and the two MSR save/restore areas, together with the MSR counts, a target-value count, a priority threshold and the priority class from the shadow page. A physical-address width and a 32-bit mode flag set which address bits must be zero.

A one-cycle `start` pulse launches a scan that evaluates one check per clock, in a fixed order. The scan stops at the first check that fails. It then raises `done` for one cycle and presents the verdict. A failure reports a check index and a two-bit failure class. The inputs must stay stable from `start` until `done`.

The sequencer has three states. IDLE waits for `start` and moves to SCAN when it arrives. SCAN steps through the checks and moves to REPORT on the first failure or after the last check. REPORT lasts one cycle with `done` high. From REPORT the block goes back to IDLE, or straight back to SCAN if `start` is high in that cycle.

Top module: `ctl_addr_validator`

## Requirements
- R1: After reset `busy`, `done` and `pass` are 0, and `fail_class` and `fail_idx` are 0.
- R2: Checks run one per cycle in index order: 0 target count, 1 bitmap A, 2 bitmap B, 3 shadow page, 4 threshold high bits, 5 threshold compare, 6 virtual NMI, 7 NMI window, 8 access page, 9 store base, 10 store end, 11 load base, 12 load end. The first failing check ends the scan. `done` rises after check index f + 2 clock edges counted from the edge that samples `start`, or after 14 edges when every check passes.
- R3: A target count greater than 4 fails check 0.
- R4: The bitmap addresses are checked only when `use_io_bitmap` is 1. The shadow page is checked only when `use_prio_shadow` is 1. The access page is checked only when the effective virtualization bit is 1. Each of these addresses fails its check if any of bits 11:0 is set.
- R5: An address fails if it sets any bit at or above the limit. The limit is `pa_width` clamped to the range 32..52. When `mode32` is 1 the limit is 32.
- R6: When an MSR count is nonzero, the matching area base address fails its base check if any of bits 3:0 is set or if it is out of range. A zero count skips both checks for that area.
- R7: When an MSR count is nonzero, the last byte address, base + count*16 - 1, is computed without wrap-around and must be within the limit.
- R8: With `use_prio_shadow` set, any nonzero bit in threshold bits 31:4 fails check 4.
- R9: With `use_prio_shadow` set and the effective virtualization bit 0, check 5 fails if threshold bits 3:0 exceed `shadow_prio`.
- R10: `virt_nmi` set with `nmi_exit` clear fails check 6. `nmi_window_exit` set with `virt_nmi` clear fails check 7.
- R11: The effective virtualization bit is `virt_ic_access` AND `secondary_on`. When `secondary_on` is 0, check 5 is enforced and check 8 is skipped.
- R12: `fail_class` is 0 on a pass, 1 for a failure at indices 0 to 8 (execution controls), and 2 for a failure at indices 9 to 12 (exit MSR areas).
- R13: `done` lasts exactly one cycle. `start` while `busy` is ignored. The verdict stays unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a scan |
| use_io_bitmap | input | 1 | I/O bitmaps in use |
| use_prio_shadow | input | 1 | Priority shadow in use |
| virt_ic_access | input | 1 | Virtualize interrupt-controller accesses (secondary) |
| nmi_exit | input | 1 | NMI exiting |
| virt_nmi | input | 1 | Virtual NMIs |
| nmi_window_exit | input | 1 | NMI-window exiting |
| secondary_on | input | 1 | Activate secondary controls |
| io_bitmap_a | input | 64 | I/O bitmap A address |
| io_bitmap_b | input | 64 | I/O bitmap B address |
| vprio_page | input | 64 | Priority-shadow page address |
| ic_access_page | input | 64 | Interrupt-controller access page address |
| exit_store_addr | input | 64 | Exit MSR-store area base |
| exit_store_cnt | input | 32 | Exit MSR-store entry count |
| exit_load_addr | input | 64 | Exit MSR-load area base |
| exit_load_cnt | input | 32 | Exit MSR-load entry count |
| target_cnt | input | 32 | Target-value count |
| prio_threshold | input | 32 | Priority threshold field |
| shadow_prio | input | 4 | Priority class (upper nibble of the shadow priority byte) |
| pa_width | input | 6 | Physical-address width |
| mode32 | input | 1 | 32-bit mode, limit fixed at 32 |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | All checks passed |
| fail_class | output | 2 | Failure class |
| fail_idx | output | 4 | Index of the failing check |

## Verification
The target count is swept from 0 to 7. Single low-order bits are swept with each enable on and off, which separates the 4-bit alignment from the 12-bit alignment and shows whether the gating is wired to the right address. Address widths from 28 to 56 are tried with addresses one page below the limit and exactly at it, in both modes. This exposes any off-by-one in the limit or its clamping. The threshold field is swept exhaustively against the priority class under every secondary/virtualization combination, and all eight NMI combinations are tried. MSR counts up to the maximum are placed so that the last byte lands exactly on the limit or one entry beyond it. Runs with several faults at once confirm that the lowest index is reported with the correct latency.

// File: rtl/cav_pkg.sv
package cav_pkg;
    localparam int ADDR_W    = 64;
    localparam int CNT_W     = 32;
    localparam int THR_W     = 32;
    localparam int PAW_W     = 6;
    localparam int LIM_W     = 7;
    localparam int MIN_PA    = 32;
    localparam int MAX_PA    = 52;
    localparam int MAX_TGT   = 4;
    localparam int PAGE_LSB  = 12;
    localparam int ENTRY_LSB = 4;
    localparam int EXT_W     = ADDR_W + CNT_W + ENTRY_LSB + 1;
    localparam int NUM_CK    = 13;
    localparam int CK_W      = $clog2(NUM_CK);

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_REPORT} seq_state_e;

    typedef enum logic [CK_W-1:0] {
        CK_TGT      = 4'd0,
        CK_IOA      = 4'd1,
        CK_IOB      = 4'd2,
        CK_VPRIO    = 4'd3,
        CK_THR_HI   = 4'd4,
        CK_THR_CMP  = 4'd5,
        CK_VNMI     = 4'd6,
        CK_NMIW     = 4'd7,
        CK_ICA      = 4'd8,
        CK_ST_BASE  = 4'd9,
        CK_ST_END   = 4'd10,
        CK_LD_BASE  = 4'd11,
        CK_LD_END   = 4'd12
    } check_e;

    localparam check_e CK_LAST = CK_LD_END;

    localparam logic [1:0] FC_NONE = 2'd0;
    localparam logic [1:0] FC_EXEC = 2'd1;
    localparam logic [1:0] FC_EXIT = 2'd2;

    function automatic logic [1:0] class_of(check_e c);
        return (c >= CK_ST_BASE) ? FC_EXIT : FC_EXEC;
    endfunction
endpackage

// File: rtl/cav_span_chk.sv
module cav_span_chk #(
    parameter int VAL_W = 101,
    parameter int LIM_W = 7
) (
    input  logic [VAL_W-1:0] value,
    input  logic [LIM_W-1:0] limit,
    output logic             in_range
);
    logic [VAL_W-1:0] above;

    for (genvar i = 0; i < VAL_W; i++) begin : g_bit
        assign above[i] = (LIM_W'(i) >= limit);
    end

    assign in_range = ~|(value & above);
endmodule

// File: rtl/cav_eval.sv
module cav_eval
    import cav_pkg::*;
(
    input  check_e             idx,
    input  logic               use_io_bitmap,
    input  logic               use_prio_shadow,
    input  logic               vic_eff,
    input  logic               nmi_exit,
    input  logic               virt_nmi,
    input  logic               nmi_window_exit,
    input  logic [ADDR_W-1:0]  io_bitmap_a,
    input  logic [ADDR_W-1:0]  io_bitmap_b,
    input  logic [ADDR_W-1:0]  vprio_page,
    input  logic [ADDR_W-1:0]  ic_access_page,
    input  logic [ADDR_W-1:0]  exit_store_addr,
    input  logic [CNT_W-1:0]   exit_store_cnt,
    input  logic [ADDR_W-1:0]  exit_load_addr,
    input  logic [CNT_W-1:0]   exit_load_cnt,
    input  logic [CNT_W-1:0]   target_cnt,
    input  logic [THR_W-1:0]   prio_threshold,
    input  logic [3:0]         shadow_prio,
    input  logic [LIM_W-1:0]   limit,
    output logic               chk_fail
);
    logic [ADDR_W-1:0] sel_addr;
    logic [CNT_W-1:0]  sel_cnt;
    logic [EXT_W-1:0]  base_ext;
    logic [EXT_W-1:0]  last_ext;
    logic              base_ok;
    logic              last_ok;
    logic              page_bad;
    logic              entry_bad;
    logic              cnt_nz;

    always_comb begin
        sel_addr = '0;
        sel_cnt  = '0;
        unique case (idx)
            CK_IOA:                 sel_addr = io_bitmap_a;
            CK_IOB:                 sel_addr = io_bitmap_b;
            CK_VPRIO:               sel_addr = vprio_page;
            CK_ICA:                 sel_addr = ic_access_page;
            CK_ST_BASE, CK_ST_END: begin
                sel_addr = exit_store_addr;
                sel_cnt  = exit_store_cnt;
            end
            CK_LD_BASE, CK_LD_END: begin
                sel_addr = exit_load_addr;
                sel_cnt  = exit_load_cnt;
            end
            default: ;
        endcase
    end

    assign base_ext  = EXT_W'(sel_addr);
    assign last_ext  = base_ext + (EXT_W'(sel_cnt) << ENTRY_LSB) - EXT_W'(1);
    assign page_bad  = |sel_addr[PAGE_LSB-1:0];
    assign entry_bad = |sel_addr[ENTRY_LSB-1:0];
    assign cnt_nz    = |sel_cnt;

    cav_span_chk #(.VAL_W(EXT_W), .LIM_W(LIM_W)) u_base_span (
        .value    (base_ext),
        .limit    (limit),
        .in_range (base_ok)
    );

    cav_span_chk #(.VAL_W(EXT_W), .LIM_W(LIM_W)) u_last_span (
        .value    (last_ext),
        .limit    (limit),
        .in_range (last_ok)
    );

    always_comb begin
        chk_fail = 1'b0;
        unique case (idx)
            CK_TGT:     chk_fail = target_cnt > CNT_W'(MAX_TGT);
            CK_IOA,
            CK_IOB:     chk_fail = use_io_bitmap && (page_bad || !base_ok);
            CK_VPRIO:   chk_fail = use_prio_shadow && (page_bad || !base_ok);
            CK_THR_HI:  chk_fail = use_prio_shadow && (|prio_threshold[THR_W-1:4]);
            CK_THR_CMP: chk_fail = use_prio_shadow && !vic_eff
                                   && (prio_threshold[3:0] > shadow_prio);
            CK_VNMI:    chk_fail = !nmi_exit && virt_nmi;
            CK_NMIW:    chk_fail = !virt_nmi && nmi_window_exit;
            CK_ICA:     chk_fail = vic_eff && (page_bad || !base_ok);
            CK_ST_BASE,
            CK_LD_BASE: chk_fail = cnt_nz && (entry_bad || !base_ok);
            CK_ST_END,
            CK_LD_END:  chk_fail = cnt_nz && !last_ok;
            default:    chk_fail = 1'b0;
        endcase
    end
endmodule

// File: rtl/cav_seq.sv
module cav_seq
    import cav_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       chk_fail,
    output check_e     idx,
    output logic       busy,
    output logic       done,
    output logic       pass,
    output logic [1:0] fail_class,
    output logic [3:0] fail_idx
);
    seq_state_e state, state_nx;
    logic       scan_end;

    assign scan_end = chk_fail || (idx == CK_LAST);
    assign busy     = (state == ST_SCAN);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SCAN;
            ST_SCAN:   if (scan_end) state_nx = ST_REPORT;
            ST_REPORT: state_nx = start ? ST_SCAN : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= CK_TGT;
            done       <= 1'b0;
            pass       <= 1'b0;
            fail_class <= FC_NONE;
            fail_idx   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE, ST_REPORT: begin
                    if (start) begin
                        idx        <= CK_TGT;
                        pass       <= 1'b0;
                        fail_class <= FC_NONE;
                        fail_idx   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (chk_fail) begin
                        done       <= 1'b1;
                        pass       <= 1'b0;
                        fail_idx   <= 4'(idx);
                        fail_class <= class_of(idx);
                    end else if (idx == CK_LAST) begin
                        done <= 1'b1;
                        pass <= 1'b1;
                    end else begin
                        idx <= check_e'(idx + 1'b1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctl_addr_validator.sv
module ctl_addr_validator
    import cav_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_io_bitmap,
    input  logic              use_prio_shadow,
    input  logic              virt_ic_access,
    input  logic              nmi_exit,
    input  logic              virt_nmi,
    input  logic              nmi_window_exit,
    input  logic              secondary_on,
    input  logic [63:0]       io_bitmap_a,
    input  logic [63:0]       io_bitmap_b,
    input  logic [63:0]       vprio_page,
    input  logic [63:0]       ic_access_page,
    input  logic [63:0]       exit_store_addr,
    input  logic [31:0]       exit_store_cnt,
    input  logic [63:0]       exit_load_addr,
    input  logic [31:0]       exit_load_cnt,
    input  logic [31:0]       target_cnt,
    input  logic [31:0]       prio_threshold,
    input  logic [3:0]        shadow_prio,
    input  logic [5:0]        pa_width,
    input  logic              mode32,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [1:0]        fail_class,
    output logic [3:0]        fail_idx
);
    check_e           idx;
    logic             chk_fail;
    logic             vic_eff;
    logic [LIM_W-1:0] limit;

    assign vic_eff = secondary_on && virt_ic_access;

    always_comb begin
        if (mode32)                          limit = LIM_W'(MIN_PA);
        else if (pa_width < PAW_W'(MIN_PA))  limit = LIM_W'(MIN_PA);
        else if (pa_width > PAW_W'(MAX_PA))  limit = LIM_W'(MAX_PA);
        else                                 limit = LIM_W'(pa_width);
    end

    cav_eval u_eval (
        .idx             (idx),
        .use_io_bitmap   (use_io_bitmap),
        .use_prio_shadow (use_prio_shadow),
        .vic_eff         (vic_eff),
        .nmi_exit        (nmi_exit),
        .virt_nmi        (virt_nmi),
        .nmi_window_exit (nmi_window_exit),
        .io_bitmap_a     (io_bitmap_a),
        .io_bitmap_b     (io_bitmap_b),
        .vprio_page      (vprio_page),
        .ic_access_page  (ic_access_page),
        .exit_store_addr (exit_store_addr),
        .exit_store_cnt  (exit_store_cnt),
        .exit_load_addr  (exit_load_addr),
        .exit_load_cnt   (exit_load_cnt),
        .target_cnt      (target_cnt),
        .prio_threshold  (prio_threshold),
        .shadow_prio     (shadow_prio),
        .limit           (limit),
        .chk_fail        (chk_fail)
    );

    cav_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chk_fail   (chk_fail),
        .idx        (idx),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .fail_class (fail_class),
        .fail_idx   (fail_idx)
    );
endmodule

// File: rtl/cav_checker.sv
module cav_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        pass,
    input logic [1:0]  fail_class,
    input logic [3:0]  fail_idx,
    input logic [31:0] target_cnt
);
    // R13: the verdict strobe never lasts two cycles
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a start seen while not scanning launches a scan
    p_start_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R12: a pass carries no failure class
    p_pass_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_class == 2'd0));

    // R12: execution-control indices map to class 1
    p_exec_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass && fail_idx < 4'd9) |-> (fail_class == 2'd1));

    // R12: exit-area indices map to class 2, and no index is past the last check
    p_exit_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass && fail_idx >= 4'd9) |-> (fail_class == 2'd2 && fail_idx <= 4'd12));

    // R3: an oversize target count can never pass
    p_target_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && target_cnt > 32'd4) |-> !pass);

    // R13: verdict holds while idle and not restarted
    p_hold_verdict_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !$past(start)) |-> $stable(pass));
endmodule

bind ctl_addr_validator cav_checker u_cav_checker (.*);

// File: tb/test_ctl_addr_validator.sv
module test_ctl_addr_validator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        use_io_bitmap, use_prio_shadow, virt_ic_access;
    logic        nmi_exit, virt_nmi, nmi_window_exit, secondary_on;
    logic [63:0] io_bitmap_a, io_bitmap_b, vprio_page, ic_access_page;
    logic [63:0] exit_store_addr, exit_load_addr;
    logic [31:0] exit_store_cnt, exit_load_cnt, target_cnt, prio_threshold;
    logic [3:0]  shadow_prio;
    logic [5:0]  pa_width;
    logic        mode32;
    logic        busy, done, pass;
    logic [1:0]  fail_class;
    logic [3:0]  fail_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ctl_addr_validator i_ctl_addr_validator (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lim_of();
        if (mode32) return 32;
        if (pa_width < 32) return 32;
        if (pa_width > 52) return 52;
        return int'(pa_width);
    endfunction

    function automatic logic oor(input logic [127:0] v);
        return (v >> lim_of()) != 0;
    endfunction

    function automatic logic [127:0] last_of(input logic [63:0] a, input logic [31:0] c);
        return {64'd0, a} + ({96'd0, c} << 4) - 128'd1;
    endfunction

    // expected first failing index, 13 means pass
    function automatic int model();
        logic ve;
        ve = secondary_on && virt_ic_access;
        if (target_cnt > 4) return 0;
        if (use_io_bitmap && (io_bitmap_a[11:0] != 0 || oor({64'd0, io_bitmap_a}))) return 1;
        if (use_io_bitmap && (io_bitmap_b[11:0] != 0 || oor({64'd0, io_bitmap_b}))) return 2;
        if (use_prio_shadow && (vprio_page[11:0] != 0 || oor({64'd0, vprio_page}))) return 3;
        if (use_prio_shadow && prio_threshold[31:4] != 0) return 4;
        if (use_prio_shadow && !ve && prio_threshold[3:0] > shadow_prio) return 5;
        if (!nmi_exit && virt_nmi) return 6;
        if (!virt_nmi && nmi_window_exit) return 7;
        if (ve && (ic_access_page[11:0] != 0 || oor({64'd0, ic_access_page}))) return 8;
        if (exit_store_cnt != 0 && (exit_store_addr[3:0] != 0 || oor({64'd0, exit_store_addr}))) return 9;
        if (exit_store_cnt != 0 && oor(last_of(exit_store_addr, exit_store_cnt))) return 10;
        if (exit_load_cnt != 0 && (exit_load_addr[3:0] != 0 || oor({64'd0, exit_load_addr}))) return 11;
        if (exit_load_cnt != 0 && oor(last_of(exit_load_addr, exit_load_cnt))) return 12;
        return 13;
    endfunction

    task automatic clear_fields();
        use_io_bitmap = 0; use_prio_shadow = 0; virt_ic_access = 0;
        nmi_exit = 0; virt_nmi = 0; nmi_window_exit = 0; secondary_on = 0;
        io_bitmap_a = 0; io_bitmap_b = 0; vprio_page = 0; ic_access_page = 0;
        exit_store_addr = 0; exit_load_addr = 0; exit_store_cnt = 0; exit_load_cnt = 0;
        target_cnt = 0; prio_threshold = 0; shadow_prio = 0; pa_width = 6'd40; mode32 = 0;
    endtask

    // launch a scan, measure latency, compare verdict; mid_start pulses start at that count
    task automatic run(input string tag, input int mid_start = 0);
        int e, n, en;
        e = model();
        en = (e == 13) ? 14 : e + 2;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        n = 1;
        while (!done && n < 100) begin
            if (mid_start != 0 && n == mid_start) start = 1;
            @(negedge clk);
            start = 0;
            n++;
        end
        chk({tag, " R2 latency"}, n, en);
        chk({tag, " pass"}, pass, (e == 13) ? 1 : 0);
        chk({tag, " R12 class"}, fail_class, (e == 13) ? 0 : ((e >= 9) ? 2 : 1));
        if (e != 13) chk({tag, " index"}, fail_idx, e);
        @(negedge clk);
        chk({tag, " R13 done pulse"}, done, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_fields();
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 0);
        chk("R1 class", fail_class, 0);
        chk("R1 idx", fail_idx, 0);
        rst_n = 1;

        run("R2 all clear");

        // R3 target count sweep
        for (int t = 0; t < 8; t++) begin
            clear_fields(); target_cnt = t;
            run("R3 target");
        end
        clear_fields(); target_cnt = 32'h8000_0000; run("R3 target huge");

        // R4 alignment with gating, per address
        for (int en = 0; en < 2; en++) begin
            for (int b = 0; b < 13; b++) begin
                clear_fields(); use_io_bitmap = en[0];
                io_bitmap_a = 64'd1 << b; run("R4 bitmap A");
                clear_fields(); use_io_bitmap = en[0];
                io_bitmap_b = 64'd1 << b; run("R4 bitmap B");
                clear_fields(); use_prio_shadow = en[0];
                vprio_page = 64'd1 << b; run("R4 shadow page");
                clear_fields(); secondary_on = 1; virt_ic_access = en[0];
                ic_access_page = 64'd1 << b; run("R4 access page");
            end
        end

        // R5 limit sweep with clamping and 32-bit mode
        for (int m = 0; m < 2; m++) begin
            for (int w = 28; w <= 56; w++) begin
                int lw;
                clear_fields(); mode32 = m[0]; pa_width = 6'(w);
                lw = lim_of();
                use_prio_shadow = 1;
                vprio_page = (64'd1 << lw) - 64'd4096; run("R5 below limit");
                vprio_page = 64'd1 << lw;              run("R5 at limit");
            end
        end
        clear_fields(); use_io_bitmap = 1; io_bitmap_b = 64'h8000_0000_0000_0000; run("R5 top bit");

        // R6 MSR base alignment and zero-count skip
        for (int b = 0; b < 6; b++) begin
            clear_fields(); exit_store_cnt = 1; exit_store_addr = 64'd1 << b; run("R6 store base");
            clear_fields(); exit_load_cnt = 3;  exit_load_addr = 64'd1 << b;  run("R6 load base");
            clear_fields(); exit_store_addr = 64'd1 << b; run("R6 store zero count");
        end
        clear_fields(); exit_load_cnt = 1; pa_width = 6'd36;
        exit_load_addr = 64'h10_0000_0000; run("R6 load base range");

        // R7 last byte exactly at limit, and one entry beyond
        begin
            logic [31:0] cs [4] = '{32'd1, 32'd2, 32'd255, 32'hFFFF_FFFF};
            for (int k = 0; k < 4; k++) begin
                clear_fields(); pa_width = 6'd40; exit_store_cnt = cs[k];
                exit_store_addr = (64'd1 << 40) - ({32'd0, cs[k]} << 4); run("R7 store fits");
                exit_store_addr = exit_store_addr + 64'd16;                run("R7 store over");
                clear_fields(); pa_width = 6'd52; exit_load_cnt = cs[k];
                exit_load_addr = (64'd1 << 52) - ({32'd0, cs[k]} << 4);    run("R7 load fits");
                exit_load_addr = exit_load_addr + 64'd16;                  run("R7 load over");
            end
        end

        // R8 threshold high bits
        for (int b = 3; b < 32; b += 4) begin
            clear_fields(); use_prio_shadow = 1; shadow_prio = 4'hF;
            prio_threshold = 32'd1 << b; run("R8 threshold high");
        end
        clear_fields(); prio_threshold = 32'hFFFF_FFF0; run("R8 shadow off");

        // R9 R11 exhaustive threshold compare across gating combinations
        for (int g = 0; g < 4; g++) begin
            for (int t = 0; t < 16; t++) begin
                for (int s = 0; s < 16; s++) begin
                    clear_fields(); use_prio_shadow = 1;
                    secondary_on = g[0]; virt_ic_access = g[1];
                    ic_access_page = 64'h1000;
                    prio_threshold = t; shadow_prio = 4'(s);
                    run("R9 R11 threshold");
                end
            end
        end
        clear_fields(); secondary_on = 0; virt_ic_access = 1; ic_access_page = 64'h7; run("R11 access page skipped");
        clear_fields(); secondary_on = 1; virt_ic_access = 1; ic_access_page = 64'h7; run("R11 access page checked");

        // R10 NMI combinations
        for (int c = 0; c < 8; c++) begin
            clear_fields(); nmi_exit = c[0]; virt_nmi = c[1]; nmi_window_exit = c[2];
            run("R10 nmi");
        end

        // R2 several faults: lowest index wins
        clear_fields(); target_cnt = 9; use_io_bitmap = 1; io_bitmap_a = 64'h1; exit_load_cnt = 1; exit_load_addr = 1;
        run("R2 multi fault A");
        clear_fields(); virt_nmi = 1; exit_store_cnt = 1; exit_store_addr = 64'h4;
        run("R2 multi fault B");

        // R13 start during scan is ignored, verdict held afterwards
        clear_fields(); exit_load_cnt = 1; exit_load_addr = 64'h3; run("R13 restart ignored", 5);
        repeat (5) @(negedge clk);
        chk("R13 held idx", fail_idx, 11);
        chk("R13 held class", fail_class, 2);
        chk("R13 held busy", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule